// File: doc/BRIEF.md
# Sample Pipeline Pointer Controller

This block steers the write and trigger pointers of a circular sample memory of 160 columns. One column is written every clock. A pipeline reset seeds both pointers so that the trigger pointer trails the write pointer by the latency applied at that moment. After an initialisation period the block accepts trigger strobes. Each accepted trigger marks one or more memory columns for read-out. The marked column addresses queue in a small address FIFO, and the read-out side takes them out with a pop strobe.

A column waiting for read-out must not be overwritten. The write pointer therefore steps over any busy column, and the trigger pointer later steps over the same columns, so the spacing between the two pointers, counted in written samples, never changes. Two watchdogs report faults on active-low flags. The first fires when the FIFO overflows or when no free column is left. The second fires when the pointer spacing no longer equals the latency input; this is checked each time the write pointer wraps. Both flags stay set until the next pipeline reset.

Top module: `pipe_ptr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block takes this state: write column 0, trigger column (160 - latency) mod 160, queue empty, `running` low, and both error flags at 1 (no error).
- R2: The write column advances by one every clock and wraps from 159 to 0. With no busy columns, the trigger column equals the write column minus the latency, mod 160.
- R3: `running` goes high once latency + 6 clocks have passed since reset. A trigger sampled while `running` is low is ignored.
- R4: A trigger sampled in cycle c takes effect in cycle c + 2. In peak mode (`peak_mode` = 1) it queues the trigger column of that cycle, which shows at the queue head one cycle later.
- R5: In deconvolution mode (`peak_mode` = 0) a trigger queues three addresses: the trigger columns of cycles c + 2, c + 3 and c + 4.
- R6: The queue hands out addresses oldest first. `q_valid` shows that an entry is present, and `pop` removes the head. A pop while the queue is empty has no effect.
- R7: The write pointer skips every column that is queued or not yet popped. The trigger pointer later skips the same columns, so no latency error arises from a skip.
- R8: After a pop the column is free again, and the write pointer lands on it on its next pass.
- R9: `fifo_err_n` goes to 0 when an address is queued while the queue already holds 19 entries. In peak mode this is the 20th trigger; in deconvolution mode it is the 7th. It also goes to 0 when no free column is left for the write pointer.
- R10: In the cycle where the write pointer wraps, the spacing between the pointers, counted without skipped columns, is compared with the `latency` input. A mismatch sets `lat_err_n` to 0 from the next cycle. Changing the latency without a reset therefore raises the error at the next wrap and not before.
- R11: Both error flags stay at 0 until the next pipeline reset, which clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Pipeline reset strobe, active high, synchronous |
| trig | input | 1 | Trigger strobe, one cycle per trigger |
| latency | input | 8 | Programmed write-to-trigger spacing in clocks |
| peak_mode | input | 1 | 1 = one address per trigger, 0 = three addresses per trigger |
| pop | input | 1 | Removes the queue head |
| q_valid | output | 1 | Queue holds at least one address |
| q_col | output | 8 | Column address at the queue head |
| wr_col | output | 8 | Current write column |
| trig_col | output | 8 | Current trigger column |
| running | output | 1 | Initialisation finished, triggers accepted |
| fifo_err_n | output | 1 | 0 = queue overflow or no free column |
| lat_err_n | output | 1 | 0 = pointer spacing differs from latency |

## Verification
On every cycle, the assertions check four things: the write pointer keeps moving, the queue stays empty until the block is running, the column at the queue head is held busy, and both error flags stay latched. Other behaviour shows only in the bench scenarios. These cover the exact columns a trigger queues in each mode, and the one-column shift of the write pointer around a protected column, followed by its return to that column after a pop. They also cover the exact trigger count at which each mode overflows, and the timing of the latency error, which appears at the wrap and not earlier.

// File: rtl/pipe_ptr_ctrl.sv
module pipe_ptr_ctrl #(
  parameter int COLS  = 160,
  parameter int DEPTH = 19,
  parameter int LAT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig,
  input  logic [LAT_W-1:0]         latency,
  input  logic                     peak_mode,
  input  logic                     pop,
  output logic                     q_valid,
  output logic [$clog2(COLS)-1:0]  q_col,
  output logic [$clog2(COLS)-1:0]  wr_col,
  output logic [$clog2(COLS)-1:0]  trig_col,
  output logic                     running,
  output logic                     fifo_err_n,
  output logic                     lat_err_n
);
  localparam int PW = $clog2(COLS);
  localparam int QW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = LAT_W + 1;

  logic [PW-1:0]   wr_ptr, trig_ptr, wr_nxt, tr_nxt;
  logic [COLS-1:0] busy, skip, wr_jump, tr_jump;
  logic            wr_found, wrap, lat_bad;
  logic [IW-1:0]   init_cnt;
  logic [LAT_W-1:0] lat_q;
  logic            s1, s2;
  logic [4:0]      mark_cnt;
  logic [5:0]      rem;
  logic            mark_now, push, do_pop, overflow;
  logic [PW-1:0]   fifo [DEPTH];
  logic [QW-1:0]   head, tail;
  logic [CW-1:0]   count;

  assign running  = init_cnt == IW'(lat_q) + IW'(6);
  assign wr_col   = wr_ptr;
  assign trig_col = trig_ptr;
  assign q_valid  = count != '0;
  assign q_col    = fifo[head];

  // next free column for writing; busy ones are stepped over and remembered
  always_comb begin
    int c;
    wr_nxt = wr_ptr; wr_found = 1'b0; wr_jump = '0;
    for (int k = 1; k < COLS; k++) begin
      c = int'(wr_ptr) + k;
      if (c >= COLS) c = c - COLS;
      if (!wr_found) begin
        if (busy[c]) wr_jump[c] = 1'b1;
        else begin wr_nxt = PW'(c); wr_found = 1'b1; end
      end
    end
    if (!wr_found) wr_jump = '0;
  end

  // trigger pointer follows the same sequence of written columns
  always_comb begin
    int c;
    logic hit;
    tr_nxt = trig_ptr; hit = 1'b0; tr_jump = '0;
    for (int k = 1; k < COLS; k++) begin
      c = int'(trig_ptr) + k;
      if (c >= COLS) c = c - COLS;
      if (!hit) begin
        if (skip[c]) tr_jump[c] = 1'b1;
        else begin tr_nxt = PW'(c); hit = 1'b1; end
      end
    end
  end

  always_comb begin
    int d, n;
    d = int'(wr_ptr) - int'(trig_ptr);
    if (d < 0) d = d + COLS;
    n = 0;
    for (int k = 0; k < COLS; k++) n = n + int'(skip[k]);
    lat_bad = (d - n) != int'(latency);
    wrap    = wr_found && (wr_nxt < wr_ptr);
  end

  assign rem      = {1'b0, mark_cnt} + (s2 ? (peak_mode ? 6'd1 : 6'd3) : 6'd0);
  assign mark_now = rem != '0;
  assign push     = mark_now && (count != CW'(DEPTH));
  assign overflow = mark_now && (count == CW'(DEPTH));
  assign do_pop   = pop && q_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      trig_ptr   <= PW'((COLS - (int'(latency) % COLS)) % COLS);
      lat_q      <= latency;
      init_cnt   <= '0;
      s1         <= 1'b0;
      s2         <= 1'b0;
      mark_cnt   <= '0;
      busy       <= '0;
      skip       <= '0;
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      fifo_err_n <= 1'b1;
      lat_err_n  <= 1'b1;
    end else begin
      if (wr_found) wr_ptr <= wr_nxt;
      else fifo_err_n <= 1'b0;
      trig_ptr <= tr_nxt;
      if (!running) init_cnt <= init_cnt + 1'b1;
      s1 <= trig && running;
      s2 <= s1;
      mark_cnt <= !mark_now ? 5'd0 : (rem - 6'd1 > 6'd31) ? 5'd31 : 5'(rem - 6'd1);
      skip <= (skip & ~tr_jump) | wr_jump;
      if (do_pop) begin
        busy[fifo[head]] <= 1'b0;
        head <= (head == QW'(DEPTH - 1)) ? '0 : head + 1'b1;
      end
      if (push) begin
        busy[trig_ptr] <= 1'b1;
        fifo[tail]     <= trig_ptr;
        tail <= (tail == QW'(DEPTH - 1)) ? '0 : tail + 1'b1;
      end
      count <= count + CW'(push) - CW'(do_pop);
      if (overflow) fifo_err_n <= 1'b0;
      if (wrap && lat_bad) lat_err_n <= 1'b0;
    end
  end

  assert_wr_steps_R2: assert property (@(posedge clk) disable iff (rst)
    fifo_err_n |=> (wr_ptr != $past(wr_ptr)) || !fifo_err_n);
  assert_no_queue_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !running |-> !q_valid);
  assert_head_held_R7: assert property (@(posedge clk) disable iff (rst)
    q_valid |-> busy[q_col]);
  assert_fifo_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !fifo_err_n |=> !fifo_err_n);
  assert_lat_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !lat_err_n |=> !lat_err_n);
endmodule

// File: tb/pipe_ptr_ctrl_test.sv
`timescale 1ns/1ps
module pipe_ptr_ctrl_test;
  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, peak_mode = 1'b1, pop = 1'b0;
  logic [7:0] latency = 8'd132;
  logic q_valid, running, fifo_err_n, lat_err_n;
  logic [7:0] q_col, wr_col, trig_col;
  int cyc = 0, checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  pipe_ptr_ctrl uut (.clk(clk), .rst(rst), .trig(trig), .latency(latency),
    .peak_mode(peak_mode), .pop(pop), .q_valid(q_valid), .q_col(q_col),
    .wr_col(wr_col), .trig_col(trig_col), .running(running),
    .fifo_err_n(fifo_err_n), .lat_err_n(lat_err_n));

  function automatic int m160(int v); return ((v % 160) + 160) % 160; endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic do_reset(int lat, bit pk);
    @(negedge clk); rst = 1'b1; latency = 8'(lat); peak_mode = pk;
    trig = 1'b0; pop = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic at_cyc(int n); while (cyc != n) @(negedge clk); endtask
  task automatic pulse_trig; trig = 1'b1; @(negedge clk); trig = 1'b0; endtask
  task automatic pulse_pop;  pop = 1'b1;  @(negedge clk); pop = 1'b0;  endtask

  task automatic t_reset;
    do_reset(132, 1'b1);
    check("R1 wr_col", wr_col, 0);
    check("R1 trig_col", trig_col, 28);
    check("R1 q_valid", q_valid, 0);
    check("R1 running", running, 0);
    check("R1 fifo_err_n", fifo_err_n, 1);
    check("R1 lat_err_n", lat_err_n, 1);
  endtask

  task automatic t_advance;
    do_reset(10, 1'b1);
    for (int i = 0; i < 172; i++) begin
      check("R2 wr_col", wr_col, m160(cyc));
      check("R2 trig_col", trig_col, m160(cyc - 10));
      @(negedge clk);
    end
    check("R10 no error on match", lat_err_n, 1);
  endtask

  task automatic t_gate;
    do_reset(10, 1'b1);
    at_cyc(15); check("R3 not running", running, 0); pulse_trig();
    check("R3 running", running, 1); pulse_trig();
    at_cyc(18); check("R3 early trigger ignored", q_valid, 0);
    at_cyc(19); check("R4 queued", q_valid, 1); check("R4 column", q_col, 8);
    pulse_pop();
    check("R6 drained", q_valid, 0);
  endtask

  task automatic t_deconv;
    do_reset(10, 1'b0);
    at_cyc(17); pulse_pop();
    check("R6 pop on empty", q_valid, 0);
    at_cyc(20); pulse_trig();
    at_cyc(26);
    check("R5 first", q_col, 12); pulse_pop();
    check("R5 second", q_col, 13); pulse_pop();
    check("R5 third", q_col, 14); check("R6 valid", q_valid, 1); pulse_pop();
    check("R6 empty after three pops", q_valid, 0);
  endtask

  task automatic t_skip;
    do_reset(10, 1'b1);
    at_cyc(20); pulse_trig();
    at_cyc(171); check("R7 before busy", wr_col, 11);
    at_cyc(172); check("R7 skip busy", wr_col, 13);
    check("R7 head", q_col, 12);
    at_cyc(300);
    check("R7 wr shifted", wr_col, 141);
    check("R7 trig shifted", trig_col, 131);
    check("R7 no latency error", lat_err_n, 1);
    pulse_pop();
    at_cyc(330); check("R8 before column", wr_col, 11);
    at_cyc(331); check("R8 column reused", wr_col, 12);
    at_cyc(400);
    check("R8 trig", trig_col, 71);
    check("R7 still no error", lat_err_n, 1);
  endtask

  task automatic t_over_peak;
    do_reset(10, 1'b1);
    at_cyc(16);
    for (int i = 0; i < 19; i++) begin pulse_trig(); @(negedge clk); end
    at_cyc(58); check("R9 peak 19 fit", fifo_err_n, 1); check("R6 oldest", q_col, 8);
    at_cyc(60); pulse_trig();
    at_cyc(66); check("R9 peak 20th", fifo_err_n, 0);
    at_cyc(90); check("R11 fifo sticky", fifo_err_n, 0);
    do_reset(10, 1'b1);
    check("R11 fifo cleared", fifo_err_n, 1);
  endtask

  task automatic t_over_deconv;
    do_reset(10, 1'b0);
    for (int i = 0; i < 6; i++) begin at_cyc(16 + 4 * i); pulse_trig(); end
    at_cyc(42); check("R9 deconv 6 fit", fifo_err_n, 1);
    at_cyc(40 + 8); check("R9 deconv 6 still fit", fifo_err_n, 1);
    pulse_trig();
    at_cyc(56); check("R9 deconv 7th", fifo_err_n, 0);
  endtask

  task automatic t_lat;
    do_reset(10, 1'b1);
    at_cyc(50); latency = 8'd12;
    at_cyc(159); check("R10 before wrap", lat_err_n, 1);
    at_cyc(160); check("R10 after wrap", lat_err_n, 0);
    at_cyc(300); check("R11 lat sticky", lat_err_n, 0);
    do_reset(12, 1'b1);
    check("R11 lat cleared", lat_err_n, 1);
    check("R1 trig for 12", trig_col, 148);
    at_cyc(170); check("R10 match after reset", lat_err_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_advance();
    t_gate();
    t_deconv();
    t_skip();
    t_over_peak();
    t_over_deconv();
    t_lat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule